// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt requests and turns them into two processor lines: a fast line for urgent sources and a normal line for everything else. Software programs each source through a word-addressed register bus. A source is first enabled. It is then classed as fast or normal. A normal source can also be bound to one of 16 ordered vector slots, and each slot holds a handler address.

When the processor takes a normal interrupt, it reads one vector register. That read returns the handler address of the lowest-numbered slot whose bound source is requesting. If no slot is requesting, the read returns a shared default address, and the handler at that address then reads the normal-status word to find the source. Fast sources do not take part in slot matching. Their handler reads the fast-status word to see which of them are requesting.

All outputs and read data are combinational functions of the request inputs and the stored configuration. Register writes take effect at the rising clock edge on which the bus write is presented.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After the synchronous, active-high reset `rst`, every stored field is zero: enables, class bits, default address, slot addresses and slot controls. Both processor lines are low.
- R2: Writing offset 0x03 sets each enable bit whose data bit is 1. Writing offset 0x04 clears each enable bit whose data bit is 1. Data bits that are 0 leave the enable unchanged. Reading either offset returns the enable mask.
- R3: Offset 0x00 reads the request inputs directly, whatever the enable and class settings are.
- R4: The class register at offset 0x05 holds one bit per source: 1 selects fast and 0 selects normal. Offset 0x01 reads request AND enable AND class. `fiqOut` is high exactly when that word is nonzero.
- R5: Offset 0x02 reads request AND enable AND NOT class. `irqOut` is high exactly when that word is nonzero.
- R6: Slot n has its handler address at offset 0x10+n and its control at offset 0x20+n. In the control word, bit 5 enables the slot and bits 4:0 give the source number. Offset 0x06 returns the address of the lowest-numbered enabled slot whose source is active in the normal-status word.
- R7: When no slot matches, offset 0x06 returns the default address held at offset 0x07.
- R8: A slot whose enable bit is 0 never matches. A source classed as fast never matches any slot, even when it is enabled and requesting.
- R9: Writes to the read-only offsets 0x00, 0x01, 0x02 and 0x06 change no state.
- R10: A slot control word stores only bits 5:0, and the other bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 means write, 0 means read |
| busAddr | input | 6 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when not selected |
| irqIn | input | 32 | Level-sensitive request inputs |
| fiqOut | output | 1 | Fast interrupt line |
| irqOut | output | 1 | Normal interrupt line |

## Verification
The bench drives several slots that request at the same time, so that a priority encoder running in the wrong direction would return a lower-priority handler. It enables a slot bound to a source classed as fast; a design that ignored the class bit would then hand out that slot's address and also raise the normal line. It uses a disabled slot that shares its source number with an active one, and it writes to read-only offsets. Either case would expose a slot that matches while disabled, or a decode that leaks writes into a neighbouring register. Set-only and clear-only enable writes with zero data bits show whether the enable register behaves as a plain overwrite.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
  localparam int ADDR_W     = 6;
  localparam int SLOT_IDX_W = 4;

  localparam logic [3:0] OFS_RAW   = 4'h0;
  localparam logic [3:0] OFS_FIQ   = 4'h1;
  localparam logic [3:0] OFS_IRQ   = 4'h2;
  localparam logic [3:0] OFS_ENSET = 4'h3;
  localparam logic [3:0] OFS_ENCLR = 4'h4;
  localparam logic [3:0] OFS_CLASS = 4'h5;
  localparam logic [3:0] OFS_VECT  = 4'h6;
  localparam logic [3:0] OFS_DEF   = 4'h7;

  localparam logic [1:0] REGION_CTRL  = 2'b00;
  localparam logic [1:0] REGION_SADDR = 2'b01;
  localparam logic [1:0] REGION_SCTL  = 2'b10;

  typedef enum logic [3:0] {
    RD_NONE, RD_RAW, RD_FIQ, RD_IRQ, RD_EN, RD_CLASS,
    RD_VECT, RD_DEF, RD_SADDR, RD_SCTL
  } rd_sel_e;

  typedef struct packed {
    logic                  enSet;
    logic                  enClr;
    logic                  classWr;
    logic                  defWr;
    logic                  slotAddrWr;
    logic                  slotCtlWr;
    logic [SLOT_IDX_W-1:0] slotIdx;
    rd_sel_e               rdSel;
  } ivc_strobe_t;
endpackage

// File: rtl/ivc_busctl.sv
`timescale 1ns/1ps
module ivc_busctl
  import ivc_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ivc_strobe_t       stb
);
  logic doWr;
  assign doWr = busSel & busWr;

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_NONE;
    stb.slotIdx = busAddr[SLOT_IDX_W-1:0];
    if (busSel) begin
      unique case (busAddr[ADDR_W-1:SLOT_IDX_W])
        REGION_CTRL: begin
          case (busAddr[SLOT_IDX_W-1:0])
            OFS_RAW:   stb.rdSel = RD_RAW;
            OFS_FIQ:   stb.rdSel = RD_FIQ;
            OFS_IRQ:   stb.rdSel = RD_IRQ;
            OFS_ENSET: begin stb.rdSel = RD_EN;    stb.enSet   = doWr; end
            OFS_ENCLR: begin stb.rdSel = RD_EN;    stb.enClr   = doWr; end
            OFS_CLASS: begin stb.rdSel = RD_CLASS; stb.classWr = doWr; end
            OFS_VECT:  stb.rdSel = RD_VECT;
            OFS_DEF:   begin stb.rdSel = RD_DEF;   stb.defWr   = doWr; end
            default:   stb.rdSel = RD_NONE;
          endcase
        end
        REGION_SADDR: begin stb.rdSel = RD_SADDR; stb.slotAddrWr = doWr; end
        REGION_SCTL:  begin stb.rdSel = RD_SCTL;  stb.slotCtlWr  = doWr; end
        default:      stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ivc_core.sv
`timescale 1ns/1ps
module ivc_core
  import ivc_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  ivc_strobe_t        stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  rdata,
  output logic               fiqOut,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] enMask
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int CTL_W = SRC_W + 1;

  logic [NUM_SRC-1:0] classSel;
  logic [DATA_W-1:0]  defAddr;
  logic [DATA_W-1:0]  slotAddr [NUM_SLOTS];
  logic [CTL_W-1:0]   slotCtl  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotHit;
  logic [NUM_SRC-1:0] fiqAct, irqAct;
  logic [DATA_W-1:0]  winAddr, vectAddr;
  logic               anyHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      enMask   <= '0;
      classSel <= '0;
      defAddr  <= '0;
    end else begin
      if (stb.enSet)   enMask   <= enMask | wdata[NUM_SRC-1:0];
      if (stb.enClr)   enMask   <= enMask & ~wdata[NUM_SRC-1:0];
      if (stb.classWr) classSel <= wdata[NUM_SRC-1:0];
      if (stb.defWr)   defAddr  <= wdata;
    end
  end

  assign fiqAct = irqIn & enMask & classSel;
  assign irqAct = irqIn & enMask & ~classSel;
  assign fiqOut = |fiqAct;
  assign irqOut = |irqAct;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slotAddr[s] <= '0;
        slotCtl[s]  <= '0;
      end else begin
        if (stb.slotAddrWr && stb.slotIdx == SLOT_IDX_W'(s))
          slotAddr[s] <= wdata;
        if (stb.slotCtlWr && stb.slotIdx == SLOT_IDX_W'(s))
          slotCtl[s] <= wdata[CTL_W-1:0];
      end
    end
    assign slotHit[s] = slotCtl[s][SRC_W] & irqAct[slotCtl[s][SRC_W-1:0]];
  end

  always_comb begin
    winAddr = '0;
    anyHit  = 1'b0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slotHit[s]) begin
        winAddr = slotAddr[s];
        anyHit  = 1'b1;
      end
    end
    vectAddr = anyHit ? winAddr : defAddr;
  end

  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      RD_RAW:   rdata[NUM_SRC-1:0] = irqIn;
      RD_FIQ:   rdata[NUM_SRC-1:0] = fiqAct;
      RD_IRQ:   rdata[NUM_SRC-1:0] = irqAct;
      RD_EN:    rdata[NUM_SRC-1:0] = enMask;
      RD_CLASS: rdata[NUM_SRC-1:0] = classSel;
      RD_VECT:  rdata = vectAddr;
      RD_DEF:   rdata = defAddr;
      RD_SADDR: if (int'(stb.slotIdx) < NUM_SLOTS) rdata = slotAddr[stb.slotIdx];
      RD_SCTL:  if (int'(stb.slotIdx) < NUM_SLOTS) rdata[CTL_W-1:0] = slotCtl[stb.slotIdx];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_vector_ctrl.sv
`timescale 1ns/1ps
module intr_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               fiqOut,
  output logic               irqOut
);
  ivc_strobe_t        stb;
  logic [NUM_SRC-1:0] enMask;

  ivc_busctl u_busctl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  ivc_core #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .wdata (busWdata),
    .irqIn (irqIn),
    .rdata (busRdata),
    .fiqOut(fiqOut),
    .irqOut(irqOut),
    .enMask(enMask)
  );
endmodule

// File: rtl/ivc_chk.sv
`timescale 1ns/1ps
module ivc_chk
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [NUM_SRC-1:0] enMask,
  input logic               fiqOut,
  input logic               irqOut
);
  logic wrSet, wrClr, wrRo;
  assign wrSet = busSel && busWr && busAddr == {2'b00, OFS_ENSET};
  assign wrClr = busSel && busWr && busAddr == {2'b00, OFS_ENCLR};
  assign wrRo  = busSel && busWr && (busAddr == {2'b00, OFS_RAW} ||
                 busAddr == {2'b00, OFS_FIQ} || busAddr == {2'b00, OFS_IRQ} ||
                 busAddr == {2'b00, OFS_VECT});

  // R1
  reset_clears_enables_chk: assert property (@(posedge clk) rst |=> enMask == '0);

  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrSet |=> ((enMask & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])) &&
              ((enMask & $past(enMask)) == $past(enMask)));

  // R2
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wrClr |=> ((enMask & $past(busWdata[NUM_SRC-1:0])) == '0) &&
              ((enMask & ~$past(enMask)) == '0));

  // R9
  readonly_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrRo |=> $stable(enMask));

  // R4
  fiq_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    fiqOut |-> |(irqIn & enMask));

  // R5
  irq_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> |(irqIn & enMask));
endmodule

bind intr_vector_ctrl ivc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ivc_chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .irqIn(irqIn), .enMask(enMask), .fiqOut(fiqOut), .irqOut(irqOut)
);

// File: tb/test_intr_vector_ctrl.sv
`timescale 1ns/1ps
module test_intr_vector_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic        busSel = 0, busWr = 0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] irqIn = '0;
  logic        fiqOut, irqOut;

  intr_vector_ctrl i_intr_vector_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int  totalCnt = 0, failCnt = 0;
  bit  done = 0;

  logic [31:0] mEn = 0, mClass = 0, mDef = 0;
  logic [31:0] mSAddr [16];
  logic [5:0]  mSCtl  [16];
  initial for (int i = 0; i < 16; i++) begin mSAddr[i] = 0; mSCtl[i] = 0; end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mVect();
    logic [31:0] act;
    act = irqIn & mEn & ~mClass;
    for (int i = 0; i < 16; i++)
      if (mSCtl[i][5] && act[mSCtl[i][4:0]]) return mSAddr[i];
    return mDef;
  endfunction

  function automatic logic [31:0] mRead(input logic [5:0] a);
    if (a[5:4] == 2'b01) return mSAddr[a[3:0]];
    if (a[5:4] == 2'b10) return {26'd0, mSCtl[a[3:0]]};
    if (a[5:4] == 2'b11) return 0;
    case (a[3:0])
      0: return irqIn;
      1: return irqIn & mEn & mClass;
      2: return irqIn & mEn & ~mClass;
      3, 4: return mEn;
      5: return mClass;
      6: return mVect();
      7: return mDef;
      default: return 0;
    endcase
  endfunction

  task automatic mWrite(input logic [5:0] a, input logic [31:0] d);
    if (a[5:4] == 2'b01) mSAddr[a[3:0]] = d;
    else if (a[5:4] == 2'b10) mSCtl[a[3:0]] = d[5:0];
    else if (a[5:4] == 2'b00)
      case (a[3:0])
        3: mEn = mEn | d;
        4: mEn = mEn & ~d;
        5: mClass = d;
        7: mDef = d;
        default: ;
      endcase
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk);
    mWrite(a, d);
    #2 busSel = 0; busWr = 0;
  endtask

  task automatic rd(input string what, input logic [5:0] a);
    @(posedge clk); #2;
    busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk);
    check(what, busRdata, mRead(a));
    #2 busSel = 0;
  endtask

  task automatic setIrq(input logic [31:0] v);
    @(posedge clk); #2 irqIn = v;
  endtask

  // Compare both processor lines against the model on every clock (R4, R5)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 fiqOut", {31'd0, fiqOut}, {31'd0, |(irqIn & mEn & mClass)});
      check("R5 irqOut", {31'd0, irqOut}, {31'd0, |(irqIn & mEn & ~mClass)});
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      totalCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1: reset state, read with inputs active to expose lines
    irqIn = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1 fiqOut after reset", {31'd0, fiqOut}, 32'd0);
    check("R1 irqOut after reset", {31'd0, irqOut}, 32'd0);
    rd("R1 enable", 6'h03);
    rd("R1 class", 6'h05);
    rd("R1 default", 6'h07);
    rd("R1 vector", 6'h06);
    rd("R1 slot0 addr", 6'h10);
    rd("R1 slot15 ctl", 6'h2F);
    // R3: raw status ignores enable and class
    setIrq(32'hA5A5_0F0F);
    rd("R3 raw", 6'h00);
    check("R3 raw literal", busRdata, 32'hA5A5_0F0F);
    // R2: set/clear semantics
    wr(6'h03, 32'h0000_00FF);
    wr(6'h03, 32'h0000_0F00);
    rd("R2 set accumulates", 6'h03);
    check("R2 set literal", busRdata, 32'h0000_0FFF);
    wr(6'h04, 32'h0000_000F);
    rd("R2 clear via clr offset", 6'h04);
    check("R2 clear literal", busRdata, 32'h0000_0FF0);
    wr(6'h04, 32'h0);
    rd("R2 zero clear no effect", 6'h03);
    // R4/R5: class split
    wr(6'h05, 32'h0000_0030);
    setIrq(32'h0000_0FF0);
    rd("R4 fiq status", 6'h01);
    check("R4 fiq literal", busRdata, 32'h0000_0030);
    rd("R5 irq status", 6'h02);
    check("R5 irq literal", busRdata, 32'h0000_0FC0);
    // R7: default only
    wr(6'h07, 32'hDEF0_0000);
    rd("R7 default returned", 6'h06);
    // slots: slot0 disabled on src 6, slot1 on fast src 4, slot3 src 9, slot7 src 6
    wr(6'h10, 32'h1000_0000); wr(6'h20, 32'h0000_0006);
    wr(6'h11, 32'h1100_0000); wr(6'h21, 32'h0000_0024);
    wr(6'h13, 32'h1300_0000); wr(6'h23, 32'h0000_0029);
    wr(6'h17, 32'h1700_0000); wr(6'h27, 32'h0000_0026);
    wr(6'h1F, 32'h1F00_0000); wr(6'h2F, 32'h0000_002B);
    // R6: both slot3 and slot7 requesting -> slot3
    setIrq(32'h0000_0250);
    rd("R6 slot3 beats slot7", 6'h06);
    check("R6 literal", busRdata, 32'h1300_0000);
    // R8: only src6 (slot0 disabled) and fast src4 -> slot7
    setIrq(32'h0000_0050);
    rd("R8 disabled/fast slots skipped", 6'h06);
    check("R8 literal", busRdata, 32'h1700_0000);
    // R6: lowest priority slot15 alone
    setIrq(32'h0000_0810);
    rd("R6 slot15 alone", 6'h06);
    check("R6 slot15 literal", busRdata, 32'h1F00_0000);
    // R7: non-vectored source only
    setIrq(32'h0000_0100);
    rd("R7 nonvectored default", 6'h06);
    check("R7 literal", busRdata, 32'hDEF0_0000);
    // R8: enable slot0 then it wins
    wr(6'h20, 32'h0000_0026);
    setIrq(32'h0000_0240);
    rd("R8 enabled slot0 wins", 6'h06);
    check("R8 slot0 literal", busRdata, 32'h1000_0000);
    // R9: writes to read-only offsets
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h01, 32'hFFFF_FFFF);
    wr(6'h02, 32'hFFFF_FFFF); wr(6'h06, 32'h1234_5678);
    rd("R9 enable unchanged", 6'h03);
    check("R9 enable literal", busRdata, 32'h0000_0FF0);
    rd("R9 class unchanged", 6'h05);
    rd("R9 default unchanged", 6'h07);
    rd("R9 vector unchanged", 6'h06);
    // R10: control width
    wr(6'h2A, 32'hFFFF_FFFF);
    rd("R10 ctl masked", 6'h2A);
    check("R10 literal", busRdata, 32'h0000_003F);
    // R4: many fast sources, all enabled
    wr(6'h03, 32'hFFFF_FFFF);
    wr(6'h05, 32'hFFFF_0000);
    setIrq(32'h8000_0001);
    rd("R4 fiq mixed", 6'h01);
    rd("R5 irq mixed", 6'h02);
    setIrq(32'h0);
    rd("R5 none active", 6'h02);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule